// File: doc/BRIEF.md
# Per-Function Outbound Request Gate

This block sits between an internal request source and a PCIe endpoint core. For each of its physical functions it keeps a stop flag that acts as if that function's bus-master enable had been switched off. A function's flag is raised by hardware when the function enters function-level reset. Only a software write lowers it, and the gate cannot know when the reset has finished.

While a function's flag is up, the gate drops any posted or non-posted request that would master the bus for that function, so the request never reaches the core. A dropped non-posted request is answered straight away on a separate error-completion port, carrying the tag, requester ID and function of the request, so the requester never waits for a timeout. Every drop latches a sticky per-function status bit, and an error interrupt stays high while any status bit is set. Completions headed outward and the whole inbound path are never touched.

Software reaches the flags and the status bits through a small register port. A MAC reset clears everything. A soft reset clears the status bits and any pending error completion, but leaves the stop flags as they are.

Top module: `flr_req_gate`

## Requirements
- R1: While `mac_rst_n` is low and on the first cycle after it rises, the stop word (address 0) and status word (address 1) read zero, `irq_err` is low and `ecpl_valid` is low.
- R2: A high `flr_enter[i]` sets stop flag i at the next clock edge. Flag i appears at bit i of address 0, and bits 31 down to 3 of every register read are zero.
- R3: While the flag of function f (f < 3) is set, a request from f of kind 0 (posted) or 1 (non-posted) is not forwarded (`fwd_valid` low). A posted drop is always accepted (`req_ready` high).
- R4: A dropped non-posted request makes `ecpl_valid` high on the next cycle, with `ecpl_fn`, `ecpl_tag` and `ecpl_rid` equal to the request's. The completion holds stable until `ecpl_ready` is high. A further non-posted drop is stalled (`req_ready` low) while the slot is full and not draining.
- R5: Every accepted drop sets status bit f (bit f of address 1) at the next edge. `irq_err` is high exactly while any status bit is set.
- R6: Status bits are cleared by writing 1 to them at address 1. Writing 0 has no effect. A drop in the same cycle as a clear leaves the bit set.
- R7: Stop flags are cleared by writing 1 to them at address 0. Writing 0 has no effect. An `flr_enter` pulse in the same cycle as a clear of that bit leaves it set.
- R8: Requests of kind 2 (completion) or 3 (reserved) and all inbound traffic (`ib_*` to `ib_out_*`) pass unchanged, whatever the flags hold.
- R9: A `soft_rst` cycle clears the status bits, `irq_err` and any pending error completion, and leaves the stop flags unchanged.
- R10: A request that is not dropped is forwarded with all fields unchanged, and `req_ready` follows `fwd_ready`. Function numbers 3 and above are never stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mac_rst_n | input | 1 | Synchronous active-low MAC reset; clears all state |
| soft_rst | input | 1 | Synchronous soft reset; clears status and pending completion |
| flr_enter | input | 3 | Per-function pulse marking entry into function-level reset |
| req_valid | input | 1 | Outbound request valid |
| req_ready | output | 1 | Outbound request accepted |
| req_kind | input | 2 | 0 posted, 1 non-posted, 2 completion, 3 reserved |
| req_fn | input | 2 | Issuing function number |
| req_tag | input | 8 | Request tag |
| req_rid | input | 16 | Requester ID |
| req_data | input | 32 | Request payload word |
| fwd_valid | output | 1 | Forwarded request valid toward the core |
| fwd_ready | input | 1 | Core accepts forwarded request |
| fwd_kind | output | 2 | Forwarded kind |
| fwd_fn | output | 2 | Forwarded function number |
| fwd_tag | output | 8 | Forwarded tag |
| fwd_rid | output | 16 | Forwarded requester ID |
| fwd_data | output | 32 | Forwarded payload |
| ecpl_valid | output | 1 | Error completion valid |
| ecpl_ready | input | 1 | Requester accepts error completion |
| ecpl_fn | output | 2 | Function of the dropped request |
| ecpl_tag | output | 8 | Tag of the dropped request |
| ecpl_rid | output | 16 | Requester ID of the dropped request |
| ib_valid | input | 1 | Inbound traffic valid from the core |
| ib_ready | output | 1 | Inbound traffic accepted |
| ib_data | input | 32 | Inbound payload |
| ib_out_valid | output | 1 | Inbound traffic valid toward the internal side |
| ib_out_ready | input | 1 | Internal side accepts inbound traffic |
| ib_out_data | output | 32 | Inbound payload passed through |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | 2 | 0 stop word, 1 status word, others read zero |
| reg_wdata | input | 3 | Write-1-to-clear mask |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_err | output | 1 | Error interrupt |

## Verification
The hardest situations to reach from the ports are same-cycle collisions: a clear write landing on the very edge where hardware sets the same bit, and a second non-posted drop arriving while the one-entry completion slot is still held by a stalled requester. The bench produces each of these on purpose. It lines up a register write with an `flr_enter` pulse or a drop on one negative edge. It holds `ecpl_ready` low across several cycles with a second request waiting, and then releases it. Around these cases, a sweep covers every stop mask against every function number and request kind.

// File: rtl/flr_gate_pkg.sv
package flr_gate_pkg;

    typedef enum logic [1:0] {
        KIND_POSTED    = 2'd0,
        KIND_NONPOSTED = 2'd1,
        KIND_CPL       = 2'd2,
        KIND_RSVD      = 2'd3
    } req_kind_e;

    localparam int ADDR_STOP = 0;
    localparam int ADDR_STAT = 1;

    function automatic logic masters_bus(input logic [1:0] kind);
        return (kind == KIND_POSTED) || (kind == KIND_NONPOSTED);
    endfunction

endpackage

// File: rtl/flr_stop_regs.sv
module flr_stop_regs #(
    parameter int NUM_FN = 3
) (
    input  logic              clk,
    input  logic              mac_rst_n,
    input  logic [NUM_FN-1:0] set_mask,
    input  logic [NUM_FN-1:0] clr_mask,
    output logic [NUM_FN-1:0] stop_q
);
    typedef struct packed {
        logic [NUM_FN-1:0] bits;
    } stop_state_t;

    stop_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set is applied after clear so a coincident entry wins
        st_d.bits = (st_q.bits & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!mac_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign stop_q = st_q.bits;
endmodule

// File: rtl/flr_disc_status.sv
module flr_disc_status #(
    parameter int NUM_FN = 3
) (
    input  logic              clk,
    input  logic              mac_rst_n,
    input  logic              soft_rst,
    input  logic [NUM_FN-1:0] set_mask,
    input  logic [NUM_FN-1:0] clr_mask,
    output logic [NUM_FN-1:0] stat_q,
    output logic              irq
);
    typedef struct packed {
        logic [NUM_FN-1:0] bits;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_rst) st_d.bits = '0;
        else          st_d.bits = (st_q.bits & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!mac_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign stat_q = st_q.bits;
    assign irq    = |st_q.bits;
endmodule

// File: rtl/flr_errcpl_slot.sv
module flr_errcpl_slot #(
    parameter int FN_W  = 2,
    parameter int TAG_W = 8,
    parameter int RID_W = 16
) (
    input  logic             clk,
    input  logic             mac_rst_n,
    input  logic             soft_rst,
    input  logic             push,
    input  logic [FN_W-1:0]  push_fn,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [RID_W-1:0] push_rid,
    output logic             can_push,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [FN_W-1:0]  out_fn,
    output logic [TAG_W-1:0] out_tag,
    output logic [RID_W-1:0] out_rid
);
    typedef struct packed {
        logic             valid;
        logic [FN_W-1:0]  fn;
        logic [TAG_W-1:0] tag;
        logic [RID_W-1:0] rid;
    } slot_state_t;

    slot_state_t st_d, st_q;

    assign can_push = !st_q.valid || out_ready;

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d.valid = 1'b0;
        end else if (push) begin
            st_d.valid = 1'b1;
            st_d.fn    = push_fn;
            st_d.tag   = push_tag;
            st_d.rid   = push_rid;
        end else if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!mac_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_fn    = st_q.fn;
    assign out_tag   = st_q.tag;
    assign out_rid   = st_q.rid;
endmodule

// File: rtl/flr_req_gate.sv
module flr_req_gate
    import flr_gate_pkg::*;
#(
    parameter int NUM_FN = 3,
    parameter int FN_W   = 2,
    parameter int TAG_W  = 8,
    parameter int RID_W  = 16,
    parameter int DATA_W = 32,
    parameter int REG_AW = 2,
    parameter int REG_DW = 32
) (
    input  logic              clk,
    input  logic              mac_rst_n,
    input  logic              soft_rst,
    input  logic [NUM_FN-1:0] flr_enter,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [DATA_W-1:0] req_data,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [1:0]        fwd_kind,
    output logic [FN_W-1:0]   fwd_fn,
    output logic [TAG_W-1:0]  fwd_tag,
    output logic [RID_W-1:0]  fwd_rid,
    output logic [DATA_W-1:0] fwd_data,
    output logic              ecpl_valid,
    input  logic              ecpl_ready,
    output logic [FN_W-1:0]   ecpl_fn,
    output logic [TAG_W-1:0]  ecpl_tag,
    output logic [RID_W-1:0]  ecpl_rid,
    input  logic              ib_valid,
    output logic              ib_ready,
    input  logic [DATA_W-1:0] ib_data,
    output logic              ib_out_valid,
    input  logic              ib_out_ready,
    output logic [DATA_W-1:0] ib_out_data,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [NUM_FN-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq_err
);
    localparam int PAD_W = REG_DW - NUM_FN;

    logic [NUM_FN-1:0] fn_sel;
    logic [NUM_FN-1:0] stop_vec;
    logic [NUM_FN-1:0] stat_vec;
    logic [NUM_FN-1:0] stop_clr;
    logic [NUM_FN-1:0] stat_clr;
    logic [NUM_FN-1:0] disc_mask;
    logic              fn_stopped;
    logic              is_master;
    logic              is_np;
    logic              drop;
    logic              drop_fire;
    logic              slot_free;
    logic              wr_stop;
    logic              wr_stat;

    // one-hot decode of the issuing function; out-of-range numbers select nothing
    for (genvar i = 0; i < NUM_FN; i++) begin : g_fn_dec
        assign fn_sel[i] = (req_fn == FN_W'(i));
    end

    assign fn_stopped = |(fn_sel & stop_vec);
    assign is_master  = masters_bus(req_kind);
    assign is_np      = (req_kind == KIND_NONPOSTED);
    assign drop       = req_valid && is_master && fn_stopped;

    always_comb begin
        if (drop) req_ready = is_np ? slot_free : 1'b1;
        else      req_ready = fwd_ready;
    end

    assign drop_fire = drop && req_ready;
    assign disc_mask = fn_sel & {NUM_FN{drop_fire}};

    assign fwd_valid = req_valid && !(is_master && fn_stopped);
    assign fwd_kind  = req_kind;
    assign fwd_fn    = req_fn;
    assign fwd_tag   = req_tag;
    assign fwd_rid   = req_rid;
    assign fwd_data  = req_data;

    assign ib_out_valid = ib_valid;
    assign ib_out_data  = ib_data;
    assign ib_ready     = ib_out_ready;

    assign wr_stop  = reg_en && reg_we && (reg_addr == REG_AW'(ADDR_STOP));
    assign wr_stat  = reg_en && reg_we && (reg_addr == REG_AW'(ADDR_STAT));
    assign stop_clr = wr_stop ? reg_wdata : '0;
    assign stat_clr = wr_stat ? reg_wdata : '0;

    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_we) begin
            if (reg_addr == REG_AW'(ADDR_STOP))      reg_rdata = {{PAD_W{1'b0}}, stop_vec};
            else if (reg_addr == REG_AW'(ADDR_STAT)) reg_rdata = {{PAD_W{1'b0}}, stat_vec};
        end
    end

    flr_stop_regs #(.NUM_FN(NUM_FN)) u_stop (
        .clk       (clk),
        .mac_rst_n (mac_rst_n),
        .set_mask  (flr_enter),
        .clr_mask  (stop_clr),
        .stop_q    (stop_vec)
    );

    flr_disc_status #(.NUM_FN(NUM_FN)) u_stat (
        .clk       (clk),
        .mac_rst_n (mac_rst_n),
        .soft_rst  (soft_rst),
        .set_mask  (disc_mask),
        .clr_mask  (stat_clr),
        .stat_q    (stat_vec),
        .irq       (irq_err)
    );

    flr_errcpl_slot #(.FN_W(FN_W), .TAG_W(TAG_W), .RID_W(RID_W)) u_slot (
        .clk       (clk),
        .mac_rst_n (mac_rst_n),
        .soft_rst  (soft_rst),
        .push      (drop_fire && is_np),
        .push_fn   (req_fn),
        .push_tag  (req_tag),
        .push_rid  (req_rid),
        .can_push  (slot_free),
        .out_valid (ecpl_valid),
        .out_ready (ecpl_ready),
        .out_fn    (ecpl_fn),
        .out_tag   (ecpl_tag),
        .out_rid   (ecpl_rid)
    );
endmodule

// File: rtl/flr_gate_chk.sv
module flr_gate_chk #(
    parameter int NUM_FN = 3,
    parameter int FN_W   = 2,
    parameter int TAG_W  = 8,
    parameter int RID_W  = 16,
    parameter int REG_AW = 2
) (
    input logic              clk,
    input logic              mac_rst_n,
    input logic              soft_rst,
    input logic [NUM_FN-1:0] flr_enter,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic [FN_W-1:0]   req_fn,
    input logic [TAG_W-1:0]  req_tag,
    input logic [RID_W-1:0]  req_rid,
    input logic              fwd_valid,
    input logic              ecpl_valid,
    input logic              ecpl_ready,
    input logic [TAG_W-1:0]  ecpl_tag,
    input logic [RID_W-1:0]  ecpl_rid,
    input logic              irq_err,
    input logic [NUM_FN-1:0] stop_vec,
    input logic              reg_en,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [NUM_FN-1:0] reg_wdata
);
    logic hit;
    logic mastering;
    logic stop_wr;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_FN; i++)
            if (req_fn == FN_W'(i) && stop_vec[i]) hit = 1'b1;
    end

    assign mastering = (req_kind == 2'd0) || (req_kind == 2'd1);
    assign stop_wr   = reg_en && reg_we && (reg_addr == '0);

    AST_FLR_SETS_STOP: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (|flr_enter) |=> ((stop_vec & $past(flr_enter)) == $past(flr_enter))); // R2

    AST_NO_FWD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (req_valid && mastering && hit) |-> !fwd_valid); // R3

    AST_ECPL_AFTER_NP_DROP: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (req_valid && req_ready && req_kind == 2'd1 && hit && !soft_rst)
        |=> (ecpl_valid && ecpl_tag == $past(req_tag) && ecpl_rid == $past(req_rid))); // R4

    AST_ECPL_HOLDS: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (ecpl_valid && !ecpl_ready && !soft_rst) |=> (ecpl_valid && $stable(ecpl_tag))); // R4

    AST_DROP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (req_valid && req_ready && mastering && hit && !soft_rst) |=> irq_err); // R5

    AST_ZERO_WRITE_KEEPS_STOP: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (stop_wr && reg_wdata == '0) |=> ((stop_vec & $past(stop_vec)) == $past(stop_vec))); // R7

    AST_NON_MASTER_PASSES: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (req_valid && !mastering) |-> fwd_valid); // R8

    AST_SOFT_KEEPS_STOP: assert property (@(posedge clk) disable iff (!mac_rst_n)
        (soft_rst && !stop_wr) |=> ((stop_vec & $past(stop_vec)) == $past(stop_vec))); // R9
endmodule

bind flr_req_gate flr_gate_chk #(
    .NUM_FN(NUM_FN), .FN_W(FN_W), .TAG_W(TAG_W), .RID_W(RID_W), .REG_AW(REG_AW)
) u_chk (
    .clk        (clk),
    .mac_rst_n  (mac_rst_n),
    .soft_rst   (soft_rst),
    .flr_enter  (flr_enter),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_kind   (req_kind),
    .req_fn     (req_fn),
    .req_tag    (req_tag),
    .req_rid    (req_rid),
    .fwd_valid  (fwd_valid),
    .ecpl_valid (ecpl_valid),
    .ecpl_ready (ecpl_ready),
    .ecpl_tag   (ecpl_tag),
    .ecpl_rid   (ecpl_rid),
    .irq_err    (irq_err),
    .stop_vec   (stop_vec),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata)
);

// File: tb/sim_flr_req_gate.sv
`timescale 1ns/1ps
module sim_flr_req_gate;
    logic        clk = 1'b0;
    logic        mac_rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [2:0]  flr_enter = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_fn = '0;
    logic [7:0]  req_tag = '0;
    logic [15:0] req_rid = '0;
    logic [31:0] req_data = '0;
    logic        fwd_valid;
    logic        fwd_ready = 1'b1;
    logic [1:0]  fwd_kind;
    logic [1:0]  fwd_fn;
    logic [7:0]  fwd_tag;
    logic [15:0] fwd_rid;
    logic [31:0] fwd_data;
    logic        ecpl_valid;
    logic        ecpl_ready = 1'b1;
    logic [1:0]  ecpl_fn;
    logic [7:0]  ecpl_tag;
    logic [15:0] ecpl_rid;
    logic        ib_valid = 1'b0;
    logic        ib_ready;
    logic [31:0] ib_data = '0;
    logic        ib_out_valid;
    logic        ib_out_ready = 1'b0;
    logic [31:0] ib_out_data;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [2:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flr_req_gate u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [2:0] m);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = m;
        tick();
        reg_en = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic flr_pulse(input logic [2:0] m);
        flr_enter = m;
        tick();
        flr_enter = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        tick(); tick();
        // R1 reset state, while reset is held and just after release
        reg_read(0, d); chk(d == 0, "R1 stop in reset", d, 0);
        mac_rst_n = 1'b1;
        #1;
        reg_read(0, d); chk(d == 0, "R1 stop after reset", d, 0);
        reg_read(1, d); chk(d == 0, "R1 status after reset", d, 0);
        chk(irq_err == 0, "R1 irq", irq_err, 0);
        chk(ecpl_valid == 0, "R1 ecpl", ecpl_valid, 0);

        // R2 entry pulses set flags, reserved bits read zero
        flr_pulse(3'b101);
        reg_read(0, d); chk(d == 32'h5, "R2 stop word", d, 5);
        reg_read(2, d); chk(d == 0, "R2 unused address", d, 0);

        // R7 write-1-to-clear, zero write, collision
        reg_write(0, 3'b000);
        reg_read(0, d); chk(d == 32'h5, "R7 zero write", d, 5);
        reg_write(0, 3'b001);
        reg_read(0, d); chk(d == 32'h4, "R7 clear bit0", d, 4);
        flr_enter = 3'b101;
        reg_write(0, 3'b100);
        flr_enter = '0;
        reg_read(0, d); chk(d == 32'h5, "R7 set wins over clear", d, 5);
        flr_enter = 3'b010;
        reg_write(0, 3'b001);
        flr_enter = '0;
        reg_read(0, d); chk(d == 32'h6, "R7 mixed set and clear", d, 6);

        // sweep: every stop mask, function number and kind (R3 R4 R5 R8 R10)
        ecpl_ready = 1'b1; fwd_ready = 1'b1;
        for (int m = 0; m < 8; m++) begin
            reg_write(0, 3'b111);
            flr_pulse(3'(m));
            for (int f = 0; f < 4; f++) begin
                for (int k = 0; k < 4; k++) begin
                    bit exp_drop;
                    logic [7:0] tg;
                    tg = 8'(m * 16 + f * 4 + k);
                    exp_drop = (k < 2) && (f < 3) && m[f];
                    req_valid = 1'b1; req_kind = 2'(k); req_fn = 2'(f);
                    req_tag = tg; req_rid = 16'h3000 + 16'(tg); req_data = 32'hA500_0000 | 32'(tg);
                    #1;
                    chk(fwd_valid == !exp_drop, exp_drop ? "R3 drop" : ((k >= 2) ? "R8 pass" : "R10 pass"), fwd_valid, !exp_drop);
                    chk(req_ready == 1'b1, "R3 ready", req_ready, 1);
                    if (!exp_drop)
                        chk(fwd_tag == tg && fwd_data == (32'hA500_0000 | 32'(tg)) && fwd_fn == 2'(f),
                            "R10 fields", fwd_tag, tg);
                    tick();
                    req_valid = 1'b0;
                    reg_read(1, d);
                    chk(d == (exp_drop ? (32'h1 << f) : 32'h0), "R5 status", d, exp_drop ? (32'h1 << f) : 0);
                    chk(irq_err == exp_drop, "R5 irq", irq_err, exp_drop);
                    chk(ecpl_valid == (exp_drop && k == 1), "R4 ecpl valid", ecpl_valid, exp_drop && k == 1);
                    if (exp_drop && k == 1)
                        chk(ecpl_tag == tg && ecpl_rid == 16'h3000 + 16'(tg) && ecpl_fn == 2'(f),
                            "R4 ecpl fields", ecpl_tag, tg);
                    reg_write(1, 3'b111);
                end
            end
        end

        // R6 status collision and zero write
        reg_write(0, 3'b111);
        flr_pulse(3'b001);
        req_valid = 1'b1; req_kind = 2'd0; req_fn = 2'd0;
        reg_write(1, 3'b001);
        req_valid = 1'b0;
        reg_read(1, d); chk(d == 32'h1, "R6 set wins over clear", d, 1);
        reg_write(1, 3'b000);
        reg_read(1, d); chk(d == 32'h1, "R6 zero write", d, 1);
        reg_write(1, 3'b001);
        reg_read(1, d); chk(d == 32'h0, "R6 clear", d, 0);
        chk(irq_err == 0, "R5 irq low when clear", irq_err, 0);

        // R4 backpressure on the error completion slot
        ecpl_ready = 1'b0;
        req_valid = 1'b1; req_kind = 2'd1; req_fn = 2'd0; req_tag = 8'h41; req_rid = 16'h0A0A;
        tick();
        req_tag = 8'h42; req_rid = 16'h0B0B;
        #1;
        chk(ecpl_valid && ecpl_tag == 8'h41, "R4 first held", ecpl_tag, 8'h41);
        chk(req_ready == 0, "R4 stall when full", req_ready, 0);
        req_kind = 2'd0;
        #1 chk(req_ready == 1, "R3 posted drop while full", req_ready, 1);
        req_kind = 2'd1;
        tick(); tick();
        chk(ecpl_tag == 8'h41 && ecpl_valid, "R4 hold stable", ecpl_tag, 8'h41);
        ecpl_ready = 1'b1;
        #1 chk(req_ready == 1, "R4 accept while draining", req_ready, 1);
        tick();
        req_valid = 1'b0;
        chk(ecpl_valid && ecpl_tag == 8'h42 && ecpl_rid == 16'h0B0B, "R4 second", ecpl_tag, 8'h42);
        tick();
        chk(ecpl_valid == 0, "R4 drained", ecpl_valid, 1'b0);

        // R10 forward backpressure, function 1 not stopped
        fwd_ready = 1'b0;
        req_valid = 1'b1; req_kind = 2'd1; req_fn = 2'd1;
        #1 chk(req_ready == 0 && fwd_valid, "R10 backpressure", req_ready, 0);
        fwd_ready = 1'b1;
        #1 chk(req_ready == 1, "R10 ready follows", req_ready, 1);
        req_valid = 1'b0;

        // R8 inbound untouched with every flag set
        flr_pulse(3'b111);
        ib_valid = 1'b1; ib_data = 32'hDEAD_BEEF; ib_out_ready = 1'b0;
        #1 chk(ib_out_valid && ib_out_data == 32'hDEAD_BEEF && !ib_ready, "R8 inbound", ib_out_data, 32'hDEAD_BEEF);
        ib_out_ready = 1'b1;
        #1 chk(ib_ready == 1, "R8 inbound ready", ib_ready, 1);
        ib_valid = 1'b0;

        // R9 soft reset keeps flags, clears status and pending completion
        ecpl_ready = 1'b0;
        req_valid = 1'b1; req_kind = 2'd1; req_fn = 2'd2; req_tag = 8'h77;
        tick();
        req_valid = 1'b0;
        chk(ecpl_valid && irq_err, "R9 precondition", {ecpl_valid, irq_err}, 2'b11);
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        reg_read(0, d); chk(d == 32'h7, "R9 flags kept", d, 7);
        reg_read(1, d); chk(d == 0, "R9 status cleared", d, 0);
        chk(irq_err == 0 && ecpl_valid == 0, "R9 irq and ecpl cleared", {irq_err, ecpl_valid}, 0);
        ecpl_ready = 1'b1;

        // R1 MAC reset clears flags
        mac_rst_n = 1'b0;
        tick();
        mac_rst_n = 1'b1;
        reg_read(0, d); chk(d == 0, "R1 MAC reset clears flags", d, 0);

        tick();
        finish_run();
    end
endmodule